// File: doc/BRIEF.md
# Trail Trace Message Capture

This block sits behind an E3 receive framer. For each received frame the framer hands over one trail-trace byte, marked by a single-cycle valid strobe. The block searches this byte stream for a start byte, which is the only byte with its top bit set. It collects that byte and the fifteen bytes after it into a staging area. When all sixteen bytes have arrived, it copies them into a sixteen-entry holding bank in one step. The host reads the holding bank through a plain address/data port.

The low seven bits of each start byte carry a CRC-7 of the message that came before it. The block keeps a running CRC-7 over each message as it arrives. When a new start byte follows a complete message directly, the block compares the two CRC values and reports a mismatch on a flag. A second flag tells the host that the stream has been stable across two whole messages in a row. A one-cycle pulse marks each refresh of the bank.

Top module: `ttm_capture`

## Requirements
- R1: While reset is high and after its release, new_message, crc_error and message_valid are 0, and every bank address reads 0x00.
- R2: A sampled byte with bit 7 = 1 starts a message and goes to bank position 0. The next fifteen sampled bytes with bit 7 = 0 fill positions 1 to 15 in arrival order.
- R3: The bank takes all sixteen bytes together, at the clock edge that samples the sixteenth byte. Until that edge, reads return the previous complete message.
- R4: new_message is high for exactly one cycle, in the cycle after the sixteenth byte is sampled, and at no other time.
- R5: A start byte that arrives before position 15 has been filled drops the partial message. That byte becomes the new position 0, and the bank is left unchanged.
- R6: After a complete message, a sampled byte with bit 7 = 0 in place of the expected start byte drops alignment. Further bytes with bit 7 = 0 are ignored until the next start byte.
- R7: The CRC-7 uses generator x^7+x^3+1 with zero preset, and each byte is shifted in MSB first. It covers all sixteen bytes of a message, with bits 6:0 of the start byte taken as zero. A start byte that directly follows a complete message sets crc_error, from the next cycle, to whether its bits 6:0 differ from that CRC.
- R8: No comparison is made at a start byte that does not directly follow a complete message. This includes the first start byte after reset. crc_error keeps its value at such a byte.
- R9: message_valid goes to 1 when a second consecutive message completes with no realignment or alignment loss in between. It goes to 0 in the cycle after any R5 or R6 event.
- R10: When byte_valid is 0, byte_in has no effect.
- R11: rd_data shows bank entry rd_addr combinationally, in the same cycle the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | Marks byte_in as one trail-trace byte of a received frame |
| byte_in | input | 8 | Trail-trace byte |
| rd_addr | input | 4 | Bank read index, 0 to 15 |
| rd_data | output | 8 | Bank entry at rd_addr |
| new_message | output | 1 | One-cycle pulse when the bank is refreshed |
| crc_error | output | 1 | Result of the most recent CRC-7 comparison |
| message_valid | output | 1 | Two or more consecutive aligned messages received |

## Verification
Two kinds of work can fall in the same cycle. The first is a start byte arriving straight after a complete message. In that cycle the block must compare against the CRC it has just finished, and it must also restart the running CRC on the new byte. The second is a bank refresh landing in the same cycle that the host reads the address being refreshed. The bench provokes both by sending messages back to back, with byte_valid held high every cycle, while it sweeps the read address on every clock. It checks each cycle against a behavioural model that computes the CRC by long division over the augmented bit stream.

// File: rtl/ttm_pkg.sv
package ttm_pkg;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned CRC_W    = 7;
    localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_FILL = 2'd1,
        ST_FULL = 2'd2
    } ttm_state_t;

    typedef struct packed {
        logic store;
        logic first;
        logic commit;
        logic compare;
    } ttm_evt_t;

    function automatic logic [CRC_W-1:0] crc7_step(
        input logic [CRC_W-1:0]  crc_in,
        input logic [BYTE_W-1:0] data
    );
        logic [CRC_W-1:0] c;
        logic             fb;
        c = crc_in;
        for (int b = BYTE_W - 1; b >= 0; b--) begin
            fb = data[b] ^ c[CRC_W-1];
            c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        return c;
    endfunction

endpackage

// File: rtl/ttm_align.sv
module ttm_align
    import ttm_pkg::*;
#(
    parameter int unsigned MSG_LEN = 16,
    localparam int unsigned IDX_W  = $clog2(MSG_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             byte_valid,
    input  logic             byte_msb,
    output ttm_evt_t         ev,
    output logic [IDX_W-1:0] wr_idx,
    output logic             message_valid
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MSG_LEN - 1);

    ttm_state_t       state_q;
    logic [IDX_W-1:0] cnt_q;
    logic [1:0]       consec_q;
    logic             mv_q;

    logic is_start, is_data, realign, lose, fill_data;

    always_comb begin
        is_start   = byte_valid & byte_msb;
        is_data    = byte_valid & ~byte_msb;
        fill_data  = is_data & (state_q == ST_FILL);
        realign    = is_start & (state_q == ST_FILL);
        lose       = is_data & (state_q == ST_FULL);
        ev         = '0;
        ev.store   = is_start | fill_data;
        ev.first   = is_start;
        ev.commit  = fill_data & (cnt_q == LAST_IDX);
        ev.compare = is_start & (state_q == ST_FULL);
        wr_idx     = is_start ? '0 : cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HUNT;
            cnt_q   <= '0;
        end else if (is_start) begin
            state_q <= ST_FILL;
            cnt_q   <= IDX_W'(1);
        end else if (ev.commit) begin
            state_q <= ST_FULL;
            cnt_q   <= '0;
        end else if (fill_data) begin
            cnt_q   <= cnt_q + IDX_W'(1);
        end else if (lose) begin
            state_q <= ST_HUNT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            consec_q <= '0;
            mv_q     <= 1'b0;
        end else if (realign | lose) begin
            consec_q <= '0;
            mv_q     <= 1'b0;
        end else if (ev.commit) begin
            if (consec_q != 2'd2) consec_q <= consec_q + 2'd1;
            mv_q <= (consec_q != 2'd0);
        end
    end

    assign message_valid = mv_q;

endmodule

// File: rtl/ttm_crc_track.sv
module ttm_crc_track
    import ttm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ttm_evt_t          ev,
    input  logic [BYTE_W-1:0] byte_in,
    output logic              crc_error
);

    logic [CRC_W-1:0]  run_q, prev_q, run_next;
    logic [BYTE_W-1:0] feed;
    logic              err_q;

    always_comb begin
        // the start byte enters with its CRC field cleared and a zero preset
        feed     = ev.first ? {byte_in[BYTE_W-1], {(BYTE_W-1){1'b0}}} : byte_in;
        run_next = crc7_step(ev.first ? '0 : run_q, feed);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            prev_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (ev.store)   run_q  <= run_next;
            if (ev.commit)  prev_q <= run_next;
            if (ev.compare) err_q  <= (byte_in[CRC_W-1:0] != prev_q);
        end
    end

    assign crc_error = err_q;

endmodule

// File: rtl/ttm_bank.sv
module ttm_bank
    import ttm_pkg::*;
#(
    parameter int unsigned MSG_LEN = 16,
    localparam int unsigned IDX_W  = $clog2(MSG_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              store,
    input  logic              commit,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [BYTE_W-1:0] rd_data
);

    logic [MSG_LEN*BYTE_W-1:0] bank_flat;

    for (genvar i = 0; i < MSG_LEN; i++) begin : g_ent
        logic [BYTE_W-1:0] ent_q;
        if (i == MSG_LEN - 1) begin : g_last
            // the final byte goes straight to the bank with the rest
            always_ff @(posedge clk) begin
                if (rst)         ent_q <= '0;
                else if (commit) ent_q <= byte_in;
            end
        end else begin : g_mid
            logic [BYTE_W-1:0] stg_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    stg_q <= '0;
                    ent_q <= '0;
                end else begin
                    if (store && wr_idx == IDX_W'(i)) stg_q <= byte_in;
                    if (commit) ent_q <= stg_q;
                end
            end
        end
        assign bank_flat[i*BYTE_W +: BYTE_W] = ent_q;
    end

    always_comb begin
        rd_data = '0;
        if (int'(rd_addr) < MSG_LEN)
            rd_data = bank_flat[int'(rd_addr)*BYTE_W +: BYTE_W];
    end

endmodule

// File: rtl/ttm_capture.sv
module ttm_capture
    import ttm_pkg::*;
#(
    parameter int unsigned MSG_LEN = 16,
    localparam int unsigned IDX_W  = $clog2(MSG_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              new_message,
    output logic              crc_error,
    output logic              message_valid
);

    ttm_evt_t         ev;
    logic [IDX_W-1:0] wr_idx;
    logic             nm_q;

    ttm_align #(.MSG_LEN(MSG_LEN)) u_align (
        .clk           (clk),
        .rst           (rst),
        .byte_valid    (byte_valid),
        .byte_msb      (byte_in[BYTE_W-1]),
        .ev            (ev),
        .wr_idx        (wr_idx),
        .message_valid (message_valid)
    );

    ttm_crc_track u_crc (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .byte_in   (byte_in),
        .crc_error (crc_error)
    );

    ttm_bank #(.MSG_LEN(MSG_LEN)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .store   (ev.store),
        .commit  (ev.commit),
        .wr_idx  (wr_idx),
        .byte_in (byte_in),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) nm_q <= 1'b0;
        else     nm_q <= ev.commit;
    end

    assign new_message = nm_q;

endmodule

// File: rtl/ttm_capture_chk.sv
module ttm_capture_chk #(
    parameter int unsigned MSG_LEN = 16,
    localparam int unsigned IDX_W  = $clog2(MSG_LEN)
) (
    input logic             clk,
    input logic             rst,
    input logic             byte_valid,
    input logic             start_bit,
    input logic [IDX_W-1:0] rd_addr,
    input logic [7:0]       rd_data,
    input logic             new_message,
    input logic             crc_error,
    input logic             message_valid
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!new_message && !crc_error && !message_valid));

    // R4
    new_message_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        new_message |=> !new_message);

    // R10
    idle_no_commit_chk: assert property (@(posedge clk) disable iff (rst)
        !byte_valid |=> !new_message);

    // R7
    crc_flag_on_start_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(crc_error) |-> $past(byte_valid && start_bit));

    // R9
    valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(message_valid) |-> new_message);

    // R3
    bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($stable(rd_addr) && !new_message) |-> $stable(rd_data));

endmodule

bind ttm_capture ttm_capture_chk #(.MSG_LEN(MSG_LEN)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .byte_valid    (byte_valid),
    .start_bit     (byte_in[7]),
    .rd_addr       (rd_addr),
    .rd_data       (rd_data),
    .new_message   (new_message),
    .crc_error     (crc_error),
    .message_valid (message_valid)
);

// File: tb/tb_ttm_capture.sv
`timescale 1ns/1ps
module tb_ttm_capture;

    localparam int N = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bv  = 1'b0;
    logic [7:0] bi  = 8'h00;
    logic [3:0] ra  = 4'd0;
    logic       sweep = 1'b0;
    logic [7:0] rd_data;
    logic       new_message, crc_error, message_valid;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    ttm_capture dut (
        .clk           (clk),
        .rst           (rst),
        .byte_valid    (bv),
        .byte_in       (bi),
        .rd_addr       (ra),
        .rd_data       (rd_data),
        .new_message   (new_message),
        .crc_error     (crc_error),
        .message_valid (message_valid)
    );

    // reference CRC: remainder of the augmented bit stream divided by 0x89
    function automatic logic [6:0] ref_crc(input logic [7:0] m [N]);
        logic [7:0] r;
        logic       bitv;
        r = 8'h00;
        for (int i = 0; i < N; i++)
            for (int b = 7; b >= 0; b--) begin
                bitv = (i == 0 && b < 7) ? 1'b0 : m[i][b];
                r = {r[6:0], bitv};
                if (r[7]) r = r ^ 8'h89;
            end
        for (int z = 0; z < 7; z++) begin
            r = {r[6:0], 1'b0};
            if (r[7]) r = r ^ 8'h89;
        end
        return r[6:0];
    endfunction

    task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    // behavioural model
    logic [7:0] m_bank [N];
    logic [7:0] q [$];
    bit         m_lock;
    int         m_consec;
    bit         m_mv, m_nm, m_err;
    logic [6:0] m_prev;

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < N; k++) m_bank[k] = 8'h00;
            q.delete();
            m_lock = 0; m_consec = 0; m_mv = 0; m_nm = 0; m_err = 0; m_prev = 7'h0;
        end else begin
            m_nm = 0;
            if (bv) begin
                if (bi[7]) begin
                    if (m_lock && q.size() == N) m_err = (bi[6:0] != m_prev);
                    else if (m_lock) begin m_consec = 0; m_mv = 0; end
                    q.delete();
                    q.push_back(bi);
                    m_lock = 1;
                end else if (m_lock) begin
                    if (q.size() == N) begin
                        m_lock = 0; q.delete(); m_consec = 0; m_mv = 0;
                    end else begin
                        q.push_back(bi);
                        if (q.size() == N) begin
                            for (int k = 0; k < N; k++) m_bank[k] = q[k];
                            m_nm = 1;
                            m_prev = ref_crc(m_bank);
                            if (m_consec < 2) m_consec++;
                            m_mv = (m_consec == 2);
                        end
                    end
                end
            end
        end
    end

    // per-cycle comparison, between edges
    always @(posedge clk) begin
        #1;
        cmp("R4", {7'h0, new_message}, {7'h0, m_nm});
        cmp("R7", {7'h0, crc_error}, {7'h0, m_err});
        cmp("R9", {7'h0, message_valid}, {7'h0, m_mv});
        cmp("R3", rd_data, m_bank[ra]);
    end

    always @(negedge clk) if (sweep) ra <= ra + 4'd1;

    logic [7:0] cur  [N];
    logic [7:0] snap [N];

    task automatic put(input logic [7:0] b, input int gap);
        @(negedge clk);
        bv = 1'b1; bi = b;
        if (gap > 0) begin
            @(negedge clk);
            bv = 1'b0; bi = 8'($urandom);   // R10: noise while not valid
            repeat (gap - 1) begin
                @(negedge clk);
                bi = 8'($urandom);
            end
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        bv = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_body(input string txt, input int gap);
        for (int i = 1; i < N; i++) begin
            cur[i] = txt[i-1] & 8'h7F;
            put(cur[i], gap);
        end
    endtask

    task automatic send_msg(input logic [6:0] crcf, input string txt, input int gap);
        cur[0] = {1'b1, crcf};
        put(cur[0], gap);
        send_body(txt, gap);
    endtask

    task automatic read_chk(input string tag, input int a, input logic [7:0] exp);
        sweep = 1'b0;
        @(negedge clk);
        ra = a[3:0];
        #1;
        cmp(tag, rd_data, exp);
    endtask

    bit done = 0;

    initial begin
        logic [6:0] good;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        for (int a = 0; a < N; a++) read_chk("R1", a, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        cmp("R1", {5'h0, new_message, crc_error, message_valid}, 8'h00);
        for (int a = 0; a < N; a++) read_chk("R1", a, 8'h00);

        // first message, bogus CRC field, gaps with noise
        sweep = 1'b1;
        send_msg(7'h55, "ABCDEFGHIJKLMNO", 2);
        idle(3);
        for (int a = 0; a < N; a++) read_chk("R2", a, cur[a]);
        read_chk("R11", 15, cur[15]);
        read_chk("R11", 0, cur[0]);
        cmp("R8", {7'h0, crc_error}, 8'h00);
        cmp("R10", rd_data, cur[0]);

        // second message back to back with correct CRC
        sweep = 1'b1;
        good = ref_crc(cur);
        send_msg(good, "PQRSTUVWXYZ0123", 0);
        idle(3);
        cmp("R7", {7'h0, crc_error}, 8'h00);
        cmp("R9", {7'h0, message_valid}, 8'h01);

        // third message with wrong CRC, back to back
        sweep = 1'b1;
        good = ref_crc(cur);
        send_msg(~good, "hello world 4u!", 0);
        idle(3);
        cmp("R7", {7'h0, crc_error}, 8'h01);
        for (int k = 0; k < N; k++) snap[k] = cur[k];

        // R5: partial message cut short by a new start byte
        sweep = 1'b1;
        put(8'h80 | 8'h23, 1);
        for (int i = 0; i < 5; i++) put(8'h30 + 8'(i), 1);
        read_chk("R5", 2, snap[2]);
        cur[0] = 8'hC4;
        put(cur[0], 1);
        idle(1);
        cmp("R5", {7'h0, message_valid}, 8'h00);
        read_chk("R5", 4, snap[4]);
        cmp("R8", {7'h0, crc_error}, 8'h01);
        sweep = 1'b1;
        send_body("realigned text.", 1);
        idle(3);
        read_chk("R5", 0, 8'hC4);
        read_chk("R2", 9, cur[9]);
        for (int k = 0; k < N; k++) snap[k] = cur[k];

        // R6: a data byte in place of the start byte drops alignment
        sweep = 1'b1;
        put(8'h41, 1);
        idle(1);
        cmp("R6", {7'h0, message_valid}, 8'h00);
        for (int i = 0; i < 20; i++) put(8'h20 + 8'(i), 0);
        idle(2);
        read_chk("R6", 15, snap[15]);
        read_chk("R6", 1, snap[1]);
        cmp("R6", {7'h0, new_message}, 8'h00);

        // recover with two messages, the second carrying the correct CRC
        sweep = 1'b1;
        send_msg(7'h11, "0123456789abcde", 0);
        good = ref_crc(cur);
        send_msg(good, "fghijklmnopqrst", 0);
        idle(3);
        cmp("R9", {7'h0, message_valid}, 8'h01);
        cmp("R7", {7'h0, crc_error}, 8'h00);
        read_chk("R10", 1, cur[1]);

        // start byte straight after completion with wrong CRC, then CRC right
        sweep = 1'b1;
        good = ref_crc(cur);
        send_msg(good ^ 7'h01, "uvwxyzUVWXYZ!?#", 0);
        put(8'h80 | {1'b0, ref_crc(cur)}, 0);
        idle(1);
        cmp("R7", {7'h0, crc_error}, 8'h00);
        idle(5);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        done = 1;
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule